// File: doc/BRIEF.md
# Word-strobe framed audio serializer

This block turns parallel audio sample words into a serial bit stream whose frames are marked by a word strobe. The serial bit clock and the word strobe arrive as plain inputs. They may come from a local divider or from an external converter that acts as timing master, and the block behaves the same either way. Both lines are brought into the system clock domain through synchronizer chains. Their edges are then detected there, so the system clock must run at least four times faster than the bit clock.

Each frame begins when the strobe moves to its active level. The active level is the configured polarity. A configuration bit chooses whether the strobe is sampled on rising bit-clock edges, with data launched on falling edges, or the other way round. A frame holds the programmed divider value plus one bit positions. Position 0 carries the most significant bit of the sample word, and the following positions step down through the word. A single holding register takes sample words over a valid/ready handshake, and each frame start consumes one word. If no word is waiting when a frame starts, the previous word is sent again and an underrun flag is raised.

Top module: `afs_serializer`

## Requirements
- R1: After reset, sd_out is 0 and underrun is 0. The holding register is empty, so s_ready is 1 as soon as the block is enabled.
- R2: With cfg_ws_pol = 1, a frame starts on a rising strobe edge. With cfg_ws_pol = 0, it starts on a falling strobe edge. The opposite strobe edge never restarts a frame.
- R3: With cfg_edge_sel = 0, the strobe is sampled on rising bit-clock edges and bit 0 is launched on the next falling edge. sd_out and underrun change only after falling bit-clock edges.
- R4: With cfg_edge_sel = 1, the edges swap roles. The strobe is sampled on falling edges, and sd_out and underrun change only after rising edges.
- R5: Frame position p carries bit SAMPLE_W-1-p of the loaded word. Positions p >= SAMPLE_W carry 0.
- R6: A frame has cfg_frame_div + 1 positions. Positions beyond cfg_frame_div carry 0 until the next frame start.
- R7: A word is accepted when s_valid and s_ready are both 1. s_ready is 1 only while the block is enabled and the holding register is empty, so it drops after an accept. Each frame start empties the register.
- R8: If the holding register is empty at a frame start, the previous word is sent again and underrun becomes 1. underrun returns to 0 at the next frame start that finds a word waiting.
- R9: While cfg_en is 0, sd_out stays 0, s_ready is 0, and no frame starts.
- R10: An active strobe edge in the middle of a frame restarts the frame at position 0 with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Block enable |
| cfg_ws_pol | input | 1 | Strobe level that opens a frame (1 = rising edge) |
| cfg_edge_sel | input | 1 | 0: sample on rising bit-clock edges, launch on falling; 1: swapped |
| cfg_frame_div | input | FLEN_W | Frame length minus one |
| sck_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word strobe, asynchronous |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | Holding register can take a word |
| s_data | input | SAMPLE_W | Sample word |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Last frame start found no new word |

## Verification
A wrong frame position counter shows on sd_out within one bit period: the most significant bit is misplaced, or a bit lands in a position that should be zero. A wrong strobe edge detector, or a stale strobe history, shows one bit clock later as a frame that restarts in the middle or never starts. The most significant bit then turns up out of place. A wrong holding-register flag shows at the next frame start, either as a repeated word where a fresh one was expected or as s_ready staying low after that frame start.

// File: rtl/afs_pkg.sv
package afs_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_pair_t;

   localparam int unsigned SCK_IDX = 0;
   localparam int unsigned WS_IDX  = 1;
   localparam int unsigned N_LINES = 2;
endpackage

// File: rtl/afs_sync_edge.sv
module afs_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  din,
   output logic                  level,
   output afs_pkg::edge_pair_t   ev
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level   = chain_q[STAGES-1];
   assign ev.rise = level & ~prev_q;
   assign ev.fall = ~level & prev_q;
endmodule

// File: rtl/afs_frame_ctl.sv
module afs_frame_ctl #(
   parameter int unsigned FLEN_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              pol,
   input  logic [FLEN_W-1:0] div,
   input  logic              sample_ev,
   input  logic              launch_ev,
   input  logic              ws_lvl,
   output logic              load,
   output logic              step,
   output logic              nxt_act,
   output logic [FLEN_W-1:0] nxt_pos
);
   logic              ws_last_q;
   logic              pend_q;
   logic              act_q;
   logic [FLEN_W-1:0] pos_q;
   logic              start_seen;

   // strobe history follows every sampling edge, enabled or not
   always_ff @(posedge clk) begin
      if (rst)            ws_last_q <= 1'b0;
      else if (sample_ev) ws_last_q <= ws_lvl;
   end

   assign start_seen = sample_ev & (pol ? (ws_lvl & ~ws_last_q)
                                        : (~ws_lvl & ws_last_q));

   always_ff @(posedge clk) begin
      if (rst || !en)      pend_q <= 1'b0;
      else if (start_seen) pend_q <= 1'b1;
      else if (launch_ev)  pend_q <= 1'b0;
   end

   assign step = en & launch_ev;
   assign load = step & pend_q;

   always_comb begin
      nxt_act = act_q;
      nxt_pos = pos_q;
      if (load) begin
         nxt_act = 1'b1;
         nxt_pos = '0;
      end else if (act_q) begin
         if (pos_q == div) nxt_act = 1'b0;
         else              nxt_pos = pos_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         act_q <= 1'b0;
         pos_q <= '0;
      end else if (step) begin
         act_q <= nxt_act;
         pos_q <= nxt_pos;
      end
   end
endmodule

// File: rtl/afs_holding.sv
module afs_holding #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic                load,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [SAMPLE_W-1:0] s_data,
   output logic [SAMPLE_W-1:0] load_word,
   output logic [SAMPLE_W-1:0] cur_word,
   output logic                underrun
);
   logic                full_q;
   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] cur_q;
   logic                ur_q;
   logic                accept;

   assign s_ready   = en & ~full_q;
   assign accept    = s_valid & s_ready;
   assign load_word = full_q ? hold_q : cur_q;
   assign cur_word  = cur_q;
   assign underrun  = ur_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (load && full_q) begin
         full_q <= 1'b0;
      end else if (accept) begin
         full_q <= 1'b1;
         hold_q <= s_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= '0;
         ur_q  <= 1'b0;
      end else if (load) begin
         cur_q <= load_word;
         ur_q  <= ~full_q;
      end
   end
endmodule

// File: rtl/afs_serializer.sv
module afs_serializer #(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned FLEN_W      = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_en,
   input  logic                cfg_ws_pol,
   input  logic                cfg_edge_sel,
   input  logic [FLEN_W-1:0]   cfg_frame_div,
   input  logic                sck_in,
   input  logic                ws_in,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [SAMPLE_W-1:0] s_data,
   output logic                sd_out,
   output logic                underrun
);
   import afs_pkg::*;

   if (SAMPLE_W < 1) begin : g_chk_w
      $error("afs_serializer: SAMPLE_W must be at least 1");
   end
   if (FLEN_W < 1) begin : g_chk_f
      $error("afs_serializer: FLEN_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      $error("afs_serializer: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] raw;
   logic [N_LINES-1:0] lvl;
   edge_pair_t         ev [N_LINES];

   assign raw[SCK_IDX] = sck_in;
   assign raw[WS_IDX]  = ws_in;

   for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
      afs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst   (rst),
         .din   (raw[gi]),
         .level (lvl[gi]),
         .ev    (ev[gi])
      );
   end

   logic sample_ev, launch_ev;
   assign sample_ev = cfg_edge_sel ? ev[SCK_IDX].fall : ev[SCK_IDX].rise;
   assign launch_ev = cfg_edge_sel ? ev[SCK_IDX].rise : ev[SCK_IDX].fall;

   logic              load, step, nxt_act;
   logic [FLEN_W-1:0] nxt_pos;

   afs_frame_ctl #(.FLEN_W(FLEN_W)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg_en),
      .pol       (cfg_ws_pol),
      .div       (cfg_frame_div),
      .sample_ev (sample_ev),
      .launch_ev (launch_ev),
      .ws_lvl    (lvl[WS_IDX]),
      .load      (load),
      .step      (step),
      .nxt_act   (nxt_act),
      .nxt_pos   (nxt_pos)
   );

   logic [SAMPLE_W-1:0] load_word, cur_word;

   afs_holding #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg_en),
      .load      (load),
      .s_valid   (s_valid),
      .s_ready   (s_ready),
      .s_data    (s_data),
      .load_word (load_word),
      .cur_word  (cur_word),
      .underrun  (underrun)
   );

   // a shift by the position past the word width leaves zero at the top
   logic [SAMPLE_W-1:0] word_src, shifted;
   assign word_src = load ? load_word : cur_word;
   assign shifted  = word_src << nxt_pos;

   always_ff @(posedge clk) begin
      if (rst || !cfg_en) sd_out <= 1'b0;
      else if (step)      sd_out <= nxt_act & shifted[SAMPLE_W-1];
   end
endmodule

// File: rtl/afs_serializer_chk.sv
module afs_serializer_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst,
   input logic cfg_en,
   input logic cfg_edge_sel,
   input logic sck_in,
   input logic s_valid,
   input logic s_ready,
   input logic sd_out,
   input logic underrun
);
   logic [SYNC_STAGES+1:0] hist_q;
   logic [7:0]             age_q;
   logic                   warm;

   always_ff @(posedge clk) begin
      hist_q <= {hist_q[SYNC_STAGES:0], sck_in};
      if (rst)                                  age_q <= '0;
      else if (age_q != 8'(SYNC_STAGES + 4))    age_q <= age_q + 8'd1;
   end

   assign warm = (age_q == 8'(SYNC_STAGES + 4));

   // R1: outputs leave reset cleared
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!sd_out && !underrun));

   // R3 and R4: serial data moves only after a launch-side bit-clock edge
   a_r3_launch_only: assert property (@(posedge clk) disable iff (rst)
      (warm && $past(cfg_en) && !$stable(sd_out)) |->
      ((hist_q[SYNC_STAGES] == $past(cfg_edge_sel)) &&
       (hist_q[SYNC_STAGES+1] != $past(cfg_edge_sel))));

   // R8: underrun is updated only at a frame start, which sits on a launch edge
   a_r8_ur_launch_only: assert property (@(posedge clk) disable iff (rst)
      (warm && $past(cfg_en) && !$stable(underrun)) |->
      ((hist_q[SYNC_STAGES] == $past(cfg_edge_sel)) &&
       (hist_q[SYNC_STAGES+1] != $past(cfg_edge_sel))));

   // R7: an accepted word fills the holding register
   a_r7_full_after_accept: assert property (@(posedge clk) disable iff (rst)
      (s_valid && s_ready) |=> !s_ready);

   // R9: disabled block drives zero
   a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> !sd_out);
endmodule

bind afs_serializer afs_serializer_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cfg_en       (cfg_en),
   .cfg_edge_sel (cfg_edge_sel),
   .sck_in       (sck_in),
   .s_valid      (s_valid),
   .s_ready      (s_ready),
   .sd_out       (sd_out),
   .underrun     (underrun)
);

// File: tb/test_afs_serializer.sv
`timescale 1ns/1ps
module test_afs_serializer;
   localparam int SW = 16;
   localparam int FW = 9;
   localparam int HALF = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0, pol = 1'b1, esel = 1'b0;
   logic [FW-1:0] div = 9'd15;
   logic          sck = 1'b1, ws = 1'b0;
   logic          sv = 1'b0;
   logic [SW-1:0] sdat = '0;
   logic          rdy, sd, ur;

   int total = 0, bad = 0;
   bit done = 0;
   logic [SW-1:0] prev_word = '0;

   always #2.5 clk = ~clk;

   afs_serializer #(.SAMPLE_W(SW), .FLEN_W(FW), .SYNC_STAGES(2)) i_afs_serializer (
      .clk(clk), .rst(rst), .cfg_en(en), .cfg_ws_pol(pol), .cfg_edge_sel(esel),
      .cfg_frame_div(div), .sck_in(sck), .ws_in(ws), .s_valid(sv), .s_ready(rdy),
      .s_data(sdat), .sd_out(sd), .underrun(ur));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_bit(input logic [SW-1:0] w, input int p, input int d);
      if (p > d || p >= SW) return 1'b0;
      return w[SW-1-p];
   endfunction

   // launch-side edge, strobe update, sample just before the sampling edge
   task automatic bit_step(input logic wsv, output logic got);
      @(negedge clk);
      sck = esel;
      ws  = wsv;
      repeat (HALF) @(negedge clk);
      got = sd;
      sck = ~esel;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic configure(input logic p, input logic e, input int d);
      logic dummy;
      @(negedge clk);
      en = 1'b0; pol = p; esel = e; div = FW'(d);
      sck = ~e; ws = ~p;
      repeat (HALF) @(negedge clk);
      bit_step(~p, dummy);
      check("R9 disabled sd_out", int'(sd), 0);
      en = 1'b1;
   endtask

   task automatic push(input logic [SW-1:0] w);
      @(negedge clk);
      check("R7 ready before accept", int'(rdy), 1);
      sv = 1'b1; sdat = w;
      @(negedge clk);
      sv = 1'b0;
      check("R7 ready after accept", int'(rdy), 0);
   endtask

   // one strobe period of len bit clocks; word w expected in the frame
   task automatic frame(input logic [SW-1:0] w, input int len, input logic exp_ur,
                        input logic on, input string req);
      logic got;
      for (int k = 0; k < len; k++) begin
         bit_step((k < (len + 1) / 2) ? pol : ~pol, got);
         if (k >= 1)
            check(req, int'(got), on ? int'(exp_bit(w, k - 1, int'(div))) : 0);
         if (k == 1 && on) check("R8 underrun flag", int'(ur), int'(exp_ur));
      end
   endtask

   task automatic fresh(input logic [SW-1:0] w, input int len, input string req);
      push(w);
      frame(w, len, 1'b0, 1'b1, req);
      prev_word = w;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_a17c));
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 sd_out after reset", int'(sd), 0);
      check("R1 underrun after reset", int'(ur), 0);
      check("R9 ready while disabled", int'(rdy), 0);
      configure(1'b1, 1'b0, 15);
      @(negedge clk);
      check("R1 ready once enabled", int'(rdy), 1);

      // R3 R5 R6: rising-sample mode, positions past the divider read zero
      fresh(16'hA5C3, 20, "R3 R5 R6 bit");
      // R5: frame longer than the word
      configure(1'b1, 1'b0, 19);
      fresh(16'h8001, 24, "R5 R6 long frame bit");
      // R8: no word waiting, previous word repeats
      frame(prev_word, 24, 1'b1, 1'b1, "R8 repeated word bit");
      fresh(16'h3C96, 24, "R8 recovery bit");
      // R2: falling-edge frame start
      configure(1'b0, 1'b0, 15);
      fresh(16'hF00D, 20, "R2 falling start bit");
      fresh(16'h1234, 18, "R2 falling start bit");
      // R4: swapped clock edges
      configure(1'b1, 1'b1, 15);
      fresh(16'hBEEF, 20, "R4 swapped edge bit");
      configure(1'b0, 1'b1, 11);
      fresh(16'h6A59, 16, "R4 swapped edge bit");
      // R10: short strobe period cuts the frame, next starts at position 0
      configure(1'b1, 1'b0, 15);
      fresh(16'hC3A5, 6, "R10 cut frame bit");
      fresh(16'h9F31, 20, "R10 restart bit");
      // R9: disabled, nothing moves
      @(negedge clk);
      en = 1'b0;
      frame(16'h0, 12, 1'b0, 1'b0, "R9 disabled bit");
      check("R9 ready while disabled", int'(rdy), 0);
      en = 1'b1;

      // constrained random frames
      for (int f = 0; f < 40; f++) begin
         if (f % 5 == 0)
            configure(1'($urandom), 1'($urandom), int'($urandom % 21));
         begin
            int len = int'(div) + 2 + int'($urandom % 4);
            logic [SW-1:0] w = SW'($urandom);
            if (f % 5 == 0 || ($urandom % 10) < 7)
               fresh(w, len, "R5 R6 random bit");
            else
               frame(prev_word, len, 1'b1, 1'b1, "R8 random repeat bit");
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule